// File: doc/BRIEF.md
# Unsigned Multiply-Accumulate Long Unit

This execution-stage datapath multiplies two unsigned 32-bit source operands and adds a 64-bit addend to the full product. The addend arrives as two 32-bit words, and the 64-bit sum leaves as two 32-bit words. Both the high and low destination words of the issuing instruction receive a part of the sum. Register file access, decode and condition evaluation happen elsewhere. The unit receives an already-resolved flag-update bit, the current four condition flags and two illegal-operand indications from decode.

Work enters through a valid/ready issue port and leaves through a valid/ready writeback port. The pipeline has four register stages: operand capture, partial products, accumulate, and flags/output. Its latency is the same for every operand value, every flag value and every mode. When the writeback consumer holds off, the whole pipeline freezes and the issue port stops accepting work. If decode has marked the operands illegal, the unit reports an error on the writeback port, requests no register write and returns the flags unchanged.

Top module: `umac_long_unit`

## Requirements
- R1: Both source operands are unsigned. The 32x32 product is computed to its full 64 bits, so all-ones times all-ones gives 0xFFFFFFFE00000001 before accumulation.
- R2: The addend is {iss_acc_hi, iss_acc_lo}, with the high word in bits 63:32. The result's bits 63:32 appear on wb_res_hi and bits 31:0 on wb_res_lo.
- R3: The result is (product + addend) mod 2^64. A carry out of bit 63 is dropped and affects no output.
- R4: Flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V. With iss_setflags=1, wb_flags[3] equals result bit 63.
- R5: With iss_setflags=1, wb_flags[2] is 1 exactly when all 64 result bits are zero.
- R6: wb_flags[1:0] always equal the issued iss_flags[1:0]. With iss_setflags=0, all four wb_flags bits equal the issued iss_flags.
- R7: If iss_bad_alias or iss_bad_index is set at issue, the writeback reports wb_err=1 and wb_write=0, with both result words zero and wb_flags equal to the issued iss_flags.
- R8: An issue accepted at clock edge k, with no writeback stall in between, is presented with wb_valid=1 from edge k+3. This holds for any data and whether or not iss_fixed_time is set.
- R9: While wb_valid=1 and wb_ready=0, the writeback outputs hold their values and iss_ready=0. No accepted issue is lost or reordered.
- R10: After synchronous reset, wb_valid=0, wb_write=0, wb_err=0 and iss_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_src_a | input | 32 | Unsigned multiplicand |
| iss_src_b | input | 32 | Unsigned multiplier |
| iss_acc_hi | input | 32 | Addend bits 63:32 |
| iss_acc_lo | input | 32 | Addend bits 31:0 |
| iss_setflags | input | 1 | Update N and Z from the result |
| iss_flags | input | 4 | Current flags, [3]=N [2]=Z [1]=C [0]=V |
| iss_fixed_time | input | 1 | Data-independent-timing mode request |
| iss_bad_alias | input | 1 | Decode found both destinations the same |
| iss_bad_index | input | 1 | Decode found an operand using the reserved index |
| wb_valid | output | 1 | Writeback item present |
| wb_ready | input | 1 | Writeback consumer accepts the item |
| wb_res_hi | output | 32 | Result bits 63:32 |
| wb_res_lo | output | 32 | Result bits 31:0 |
| wb_flags | output | 4 | Flags after the operation |
| wb_write | output | 1 | Destination registers are to be written |
| wb_err | output | 1 | Illegal-operand error |

## Verification
Some properties are checked by assertions on every cycle. One is the four-edge latency from an accepted issue. Another is output stability while writeback is stalled. The rest are the flag rules: C and V pass through, N and Z follow the presented result, all flags pass through when the update is off, and an error item never requests a write and carries a zero result. The numeric correctness of the 64-bit product-plus-addend cannot be shown by an assertion. The bench scenarios check it against a 128-bit reference: the all-ones corner with its carry out of bit 63, results that are zero or wrap to zero, addend-only sums, and random operands. The bench scenarios also show that no item is lost or reordered under random backpressure.

// File: rtl/umac_pkg.sv
package umac_pkg;
  localparam int NFLAG = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  typedef struct packed {
    logic             valid;
    logic             setflags;
    logic             err;
    logic [NFLAG-1:0] flags;
  } umac_ctl_t;
endpackage

// File: rtl/umac_capture.sv
module umac_capture
  import umac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW = 2 * XLEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  acc_hi,
  input  logic [XLEN-1:0]  acc_lo,
  input  logic             setflags,
  input  logic [NFLAG-1:0] flags,
  input  logic             bad_alias,
  input  logic             bad_index,
  output logic [XLEN-1:0]  a_q,
  output logic [XLEN-1:0]  b_q,
  output logic [PW-1:0]    addend_q,
  output umac_ctl_t        ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (en) begin
      ctl_q.valid    <= in_valid;
      ctl_q.setflags <= setflags;
      ctl_q.err      <= bad_alias | bad_index;
      ctl_q.flags    <= flags;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_q      <= src_a;
      b_q      <= src_b;
      addend_q <= {acc_hi, acc_lo};
    end
  end
endmodule

// File: rtl/umac_mul_stage.sv
module umac_mul_stage
  import umac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW = 2 * XLEN,
  localparam int H  = XLEN / 2,
  localparam int NPP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [PW-1:0]   addend_i,
  input  umac_ctl_t       ctl_i,
  output logic [XLEN-1:0] pp_q [NPP],
  output logic [PW-1:0]   addend_q,
  output umac_ctl_t       ctl_q
);
  logic [XLEN-1:0] pp_c [NPP];

  // Index gi*2+gj: half gi of a times half gj of b, weight (gi+gj)*H.
  for (genvar gi = 0; gi < 2; gi++) begin : g_ahalf
    for (genvar gj = 0; gj < 2; gj++) begin : g_bhalf
      assign pp_c[gi*2+gj] = XLEN'(a_i[gi*H +: H]) * XLEN'(b_i[gj*H +: H]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (en) begin
      ctl_q <= ctl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      pp_q     <= pp_c;
      addend_q <= addend_i;
    end
  end
endmodule

// File: rtl/umac_acc_stage.sv
module umac_acc_stage
  import umac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW = 2 * XLEN,
  localparam int H  = XLEN / 2,
  localparam int NPP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] pp_i [NPP],
  input  logic [PW-1:0]   addend_i,
  input  umac_ctl_t       ctl_i,
  output logic [PW-1:0]   sum_q,
  output umac_ctl_t       ctl_q
);
  logic [PW-1:0] mid_a;
  logic [PW-1:0] mid_b;
  logic [PW-1:0] sum_c;

  always_comb begin
    mid_a = PW'(pp_i[1]) << H;
    mid_b = PW'(pp_i[2]) << H;
    // Sum wraps at PW bits: any carry out of the top bit is dropped.
    sum_c = {pp_i[3], pp_i[0]} + mid_a + mid_b + addend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (en) begin
      ctl_q <= ctl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en) sum_q <= sum_c;
  end
endmodule

// File: rtl/umac_out_stage.sv
module umac_out_stage
  import umac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW = 2 * XLEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PW-1:0]    sum_i,
  input  umac_ctl_t        ctl_i,
  output logic             valid_q,
  output logic [PW-1:0]    res_q,
  output logic [NFLAG-1:0] flags_q,
  output logic             write_q,
  output logic             err_q
);
  logic             sf_q;
  logic [NFLAG-1:0] flags_c;

  always_comb begin
    flags_c = ctl_i.flags;
    if (ctl_i.setflags && !ctl_i.err) begin
      flags_c[FLG_N] = sum_i[PW-1];
      flags_c[FLG_Z] = (sum_i == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      sf_q    <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else if (en) begin
      valid_q <= ctl_i.valid;
      write_q <= ctl_i.valid && !ctl_i.err;
      err_q   <= ctl_i.valid && ctl_i.err;
      sf_q    <= ctl_i.setflags;
      res_q   <= ctl_i.err ? '0 : sum_i;
      flags_q <= flags_c;
    end
  end

  a_r4_n_is_top_bit: assert property (@(posedge clk) disable iff (rst)
    (valid_q && write_q && sf_q) |-> (flags_q[FLG_N] == res_q[PW-1]));

  a_r5_z_all_bits: assert property (@(posedge clk) disable iff (rst)
    (valid_q && write_q && sf_q) |-> (flags_q[FLG_Z] == (res_q == '0)));

  a_r6_cv_pass: assert property (@(posedge clk) disable iff (rst)
    (en && ctl_i.valid) |=> (flags_q[FLG_C] == $past(ctl_i.flags[FLG_C]) &&
                             flags_q[FLG_V] == $past(ctl_i.flags[FLG_V])));

  a_r6_no_update: assert property (@(posedge clk) disable iff (rst)
    (en && ctl_i.valid && !ctl_i.setflags) |=> (flags_q == $past(ctl_i.flags)));

  a_r7_err_no_write: assert property (@(posedge clk) disable iff (rst)
    (valid_q && err_q) |-> (!write_q && res_q == '0));
endmodule

// File: rtl/umac_long_unit.sv
module umac_long_unit
  import umac_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int PW = 2 * XLEN,
  localparam int NPP = 4,
  localparam int LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [XLEN-1:0]  iss_src_a,
  input  logic [XLEN-1:0]  iss_src_b,
  input  logic [XLEN-1:0]  iss_acc_hi,
  input  logic [XLEN-1:0]  iss_acc_lo,
  input  logic             iss_setflags,
  input  logic [NFLAG-1:0] iss_flags,
  input  logic             iss_fixed_time,
  input  logic             iss_bad_alias,
  input  logic             iss_bad_index,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [XLEN-1:0]  wb_res_hi,
  output logic [XLEN-1:0]  wb_res_lo,
  output logic [NFLAG-1:0] wb_flags,
  output logic             wb_write,
  output logic             wb_err
);
  logic            en;
  logic            iss_fire;
  logic [XLEN-1:0] a_s1;
  logic [XLEN-1:0] b_s1;
  logic [PW-1:0]   add_s1;
  umac_ctl_t       ctl_s1;
  logic [XLEN-1:0] pp_s2 [NPP];
  logic [PW-1:0]   add_s2;
  umac_ctl_t       ctl_s2;
  logic [PW-1:0]   sum_s3;
  umac_ctl_t       ctl_s3;
  logic [PW-1:0]   res;

  // Global advance: the pipeline freezes only while an item waits at writeback.
  assign en        = !(wb_valid && !wb_ready);
  assign iss_ready = en;
  assign iss_fire  = iss_valid && en;

  umac_capture #(.XLEN(XLEN)) cap_i (
    .clk(clk), .rst(rst), .en(en), .in_valid(iss_valid),
    .src_a(iss_src_a), .src_b(iss_src_b),
    .acc_hi(iss_acc_hi), .acc_lo(iss_acc_lo),
    .setflags(iss_setflags), .flags(iss_flags),
    .bad_alias(iss_bad_alias), .bad_index(iss_bad_index),
    .a_q(a_s1), .b_q(b_s1), .addend_q(add_s1), .ctl_q(ctl_s1)
  );

  umac_mul_stage #(.XLEN(XLEN)) mul_i (
    .clk(clk), .rst(rst), .en(en),
    .a_i(a_s1), .b_i(b_s1), .addend_i(add_s1), .ctl_i(ctl_s1),
    .pp_q(pp_s2), .addend_q(add_s2), .ctl_q(ctl_s2)
  );

  umac_acc_stage #(.XLEN(XLEN)) acc_i (
    .clk(clk), .rst(rst), .en(en),
    .pp_i(pp_s2), .addend_i(add_s2), .ctl_i(ctl_s2),
    .sum_q(sum_s3), .ctl_q(ctl_s3)
  );

  umac_out_stage #(.XLEN(XLEN)) out_i (
    .clk(clk), .rst(rst), .en(en),
    .sum_i(sum_s3), .ctl_i(ctl_s3),
    .valid_q(wb_valid), .res_q(res), .flags_q(wb_flags),
    .write_q(wb_write), .err_q(wb_err)
  );

  assign wb_res_hi = res[PW-1:XLEN];
  assign wb_res_lo = res[XLEN-1:0];

  // Edges seen since reset, saturating; keeps $past windows inside reset history.
  logic [2:0] edges_q;
  always_ff @(posedge clk) begin
    if (rst) edges_q <= '0;
    else if (edges_q != 3'd7) edges_q <= edges_q + 3'd1;
  end

  a_r8_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    (edges_q > 3'd4 && $past(iss_fire, LAT+1) && $past(en, 3) && $past(en, 2) && $past(en, 1))
    |-> wb_valid);

  a_r8_fixed_time_mode: assert property (@(posedge clk) disable iff (rst)
    (edges_q > 3'd4 && $past(iss_fire && iss_fixed_time, LAT+1) &&
     $past(en, 3) && $past(en, 2) && $past(en, 1)) |-> wb_valid);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_res_hi) && $stable(wb_res_lo) &&
                                 $stable(wb_flags) && $stable(wb_err)));
endmodule

// File: tb/umac_long_unit_tb_top.sv
module umac_long_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [31:0] iss_src_a = '0, iss_src_b = '0, iss_acc_hi = '0, iss_acc_lo = '0;
  logic        iss_setflags = 1'b0;
  logic [3:0]  iss_flags = '0;
  logic        iss_fixed_time = 1'b0, iss_bad_alias = 1'b0, iss_bad_index = 1'b0;
  logic        wb_valid, wb_ready = 1'b1;
  logic [31:0] wb_res_hi, wb_res_lo;
  logic [3:0]  wb_flags;
  logic        wb_write, wb_err;

  umac_long_unit dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_acc_hi(iss_acc_hi), .iss_acc_lo(iss_acc_lo),
    .iss_setflags(iss_setflags), .iss_flags(iss_flags),
    .iss_fixed_time(iss_fixed_time), .iss_bad_alias(iss_bad_alias),
    .iss_bad_index(iss_bad_index), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_res_hi(wb_res_hi), .wb_res_lo(wb_res_lo), .wb_flags(wb_flags),
    .wb_write(wb_write), .wb_err(wb_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    logic [3:0]  fl;
    logic        err;
    int          cyc;
    logic        lat;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cyc = 0, npush = 0, npop = 0;
  logic bp_on = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Driver: called just after a rising edge; returns just after the accepting edge.
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] hi,
                       input logic [31:0] lo, input logic sf, input logic [3:0] fl,
                       input logic ba, input logic bi, input logic ft, input string tag);
    logic [127:0] full;
    logic [63:0]  r;
    exp_t e;
    #1;
    iss_valid = 1'b1; iss_src_a = a; iss_src_b = b; iss_acc_hi = hi; iss_acc_lo = lo;
    iss_setflags = sf; iss_flags = fl; iss_bad_alias = ba; iss_bad_index = bi;
    iss_fixed_time = ft;
    full = 128'(a) * 128'(b) + {64'd0, hi, lo};
    r    = full[63:0];
    e.err = ba | bi;
    e.hi  = e.err ? 32'd0 : r[63:32];
    e.lo  = e.err ? 32'd0 : r[31:0];
    e.fl  = (sf && !e.err) ? {r[63], (r == 64'd0), fl[1:0]} : fl;
    e.lat = !bp_on;
    e.tag = tag;
    forever begin
      @(negedge clk);
      if (iss_ready) break;
    end
    e.cyc = cyc + 1;
    q.push_back(e);
    npush++;
    @(posedge clk);
  endtask

  // Monitor: compare each accepted writeback against the scoreboard.
  logic        stalled_prev = 1'b0;
  logic [31:0] hold_hi, hold_lo;
  logic [3:0]  hold_fl;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled_prev) begin
        chk(wb_valid && wb_res_hi == hold_hi && wb_res_lo == hold_lo && wb_flags == hold_fl,
            "R9 stall hold", {wb_res_hi, wb_res_lo}, {hold_hi, hold_lo});
      end
      stalled_prev = wb_valid && !wb_ready;
      hold_hi = wb_res_hi; hold_lo = wb_res_lo; hold_fl = wb_flags;
      if (wb_valid && wb_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected writeback", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          npop++;
          chk({wb_res_hi, wb_res_lo} == {e.hi, e.lo}, {"R1 R2 R3 result ", e.tag},
              {wb_res_hi, wb_res_lo}, {e.hi, e.lo});
          chk(wb_flags[3] == e.fl[3], {"R4 N ", e.tag}, 64'(wb_flags), 64'(e.fl));
          chk(wb_flags[2] == e.fl[2], {"R5 Z ", e.tag}, 64'(wb_flags), 64'(e.fl));
          chk(wb_flags[1:0] == e.fl[1:0], {"R6 C V ", e.tag}, 64'(wb_flags), 64'(e.fl));
          chk(wb_err == e.err && wb_write == !e.err, {"R7 err/write ", e.tag},
              64'({wb_err, wb_write}), 64'({e.err, !e.err}));
          if (e.lat) chk(cyc == e.cyc + 3, {"R8 latency ", e.tag}, 64'(cyc), 64'(e.cyc + 3));
        end
      end
    end
  end

  // Writeback backpressure source.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      wb_ready = bp_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic drain();
    #1;
    iss_valid = 1'b0;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!wb_valid && !wb_write && !wb_err, "R10 reset outputs", 64'({wb_valid, wb_write, wb_err}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(iss_ready == 1'b1, "R10 ready after reset", 64'(iss_ready), 64'd1);
    @(posedge clk);

    // Directed corners.
    issue('1, '1, '1, '1, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b0, "R1 R3 all-ones with carry out");
    issue(32'd0, 32'd123, 32'd0, 32'd0, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, "R5 zero result");
    issue(32'd1, 32'd1, '1, '1, 1'b1, 4'b1010, 1'b0, 1'b0, 1'b1, "R3 R5 wrap to zero");
    issue(32'd0, 32'd7, 32'd0, 32'd0, 1'b0, 4'b0101, 1'b0, 1'b0, 1'b0, "R6 no update");
    issue(32'h0, 32'h9, 32'h8000_1234, 32'h5678_9abc, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, "R2 addend only");
    issue(32'hffff_0000, 32'h0001_ffff, 32'h1, 32'h0, 1'b1, 4'b0110, 1'b0, 1'b0, 1'b1, "R1 R4 mixed halves");
    issue(32'd5, 32'd6, 32'd0, 32'd0, 1'b1, 4'b1111, 1'b1, 1'b0, 1'b0, "R7 alias");
    issue(32'd5, 32'd6, 32'd1, 32'd2, 1'b1, 4'b0001, 1'b0, 1'b1, 1'b1, "R7 index");
    issue('1, '1, '1, '1, 1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, "R8 fixed-time all-ones");

    // Random, no backpressure.
    for (int i = 0; i < 200; i++) begin
      issue($urandom, $urandom, $urandom, $urandom, 1'($urandom % 2), 4'($urandom),
            1'(($urandom % 16) == 0), 1'(($urandom % 16) == 0), 1'($urandom % 2), "random");
    end
    drain();

    // Random with backpressure.
    bp_on = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 300; i++) begin
      issue($urandom, $urandom, $urandom, $urandom, 1'($urandom % 2), 4'($urandom),
            1'(($urandom % 16) == 0), 1'(($urandom % 16) == 0), 1'($urandom % 2), "R9 backpressure");
    end
    drain();
    bp_on = 1'b0;
    repeat (3) @(posedge clk);
    chk(npop == npush, "R9 no loss", 64'(npop), 64'(npush));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule